// File: doc/BRIEF.md
# Configurable Interrupt Source Capture

This block captures interrupt requests from a bank of system sources, all synchronous to its clock. Each source has its own trigger mode. A polarity bit and a type bit select one of four modes: rising edge, falling edge, active-high level or active-low level. A detected trigger latches a pending bit, and that bit stays set until software clears it. An enable bit for each source and one global enable bit then mask the pending vector before it goes to a downstream priority stage.

Software reaches the block through a single-cycle write port and a combinational read port. Pending and enable bits are changed by index: software writes a source number to a dedicated set or clear register and does not have to read, modify and write a bitmask. Two bulk registers clear many pending bits or many enable bits in one write. The polarity and type vectors are written as whole words.

Top module: `irq_src_capture`

## Requirements
- R1: After reset, every pending bit, every enable bit and the global enable are 0, the polarity vector is all ones, the type vector is all zeros, and `irq_o` is 0.
- R2: Register addresses are as follows. 0 is the global enable (bit 0). 1 is the pending vector: a read returns it, and a write clears each bit whose data bit is 1. 2 is the enable vector: a read returns it, and a write clears each bit whose data bit is 1. 3 is pending clear by index. 4 is enable set by index. 5 is enable clear by index. 6 is the polarity vector (read/write). 7 is the type vector (read/write). Index writes take the source number from data bits [4:0]. A read of any other address returns 0.
- R3: With type=1 and polarity=1, a 0-to-1 change of a source sets its pending bit at the next clock edge. The bit stays set after the input returns low, until it is cleared.
- R4: With type=1 and polarity=0, a 1-to-0 change of a source sets its pending bit and the bit stays set until it is cleared.
- R5: With type=0 and polarity=1, a high input sets the pending bit. A clear while the input is still high leaves the bit set. A clear after the input has gone low resets the bit.
- R6: With type=0 and polarity=0, a low input sets the pending bit. The bit stays set until it is cleared.
- R7: A write of a source number to the pending-clear-by-index register clears that pending bit only.
- R8: Enable-set-by-index and enable-clear-by-index change only the enable bit of the indexed source.
- R9: Writing all ones to the bulk pending clear register clears every pending bit. Writing all ones to the bulk enable clear register clears every enable bit.
- R10: While the global enable is 0, `irq_o` is 0 whatever the pending and enable state.
- R11: If a trigger and a clear of the same source fall in the same cycle, the pending bit is set after that cycle.
- R12: Pending bits are recorded whatever the enable bit is. Enabling a source later shows its pending bit on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Synchronous interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 32 | Pending, enabled and globally gated requests |

## Verification
Two things can hit one pending bit in the same cycle: a trigger arriving on the source input, and a software clear of that bit by index. The bench provokes this in three ways. It drives a rising edge in the same cycle as the index clear of that source. It issues a clear while a high-level source is still active. It clears one source while another is pending. In every case it judges the result one cycle later, at `irq_o` and by reading the pending register: the pending bit must be set, and neighbouring sources must be left untouched.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_GLB       = 4'h0,
    REG_PEND      = 4'h1,
    REG_EN        = 4'h2,
    REG_PEND_ICLR = 4'h3,
    REG_EN_ISET   = 4'h4,
    REG_EN_ICLR   = 4'h5,
    REG_POL       = 4'h6,
    REG_TYPE      = 4'h7
  } reg_addr_e;

  // {type, pol} trigger encoding
  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'b00,
    TRIG_LVL_HI = 2'b01,
    TRIG_FALL   = 2'b10,
    TRIG_RISE   = 2'b11
  } trig_e;

endpackage

// File: rtl/irq_cap_regfile.sv
module irq_cap_regfile
  import irq_cap_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [N_SRC-1:0]    pend_i,
  output logic [N_SRC-1:0]    pend_clr_o,
  output logic [N_SRC-1:0]    en_o,
  output logic [N_SRC-1:0]    pol_o,
  output logic [N_SRC-1:0]    type_o,
  output logic                glb_o
);

  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam bit          POW2  = (N_SRC == (1 << IDX_W));

  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [N_SRC-1:0] idx_hot;
  logic [N_SRC-1:0] wmask;
  logic [N_SRC-1:0] en_q, pol_q, type_q;
  logic             glb_q;
  logic             wr_glb, wr_pend, wr_en, wr_piclr, wr_eset, wr_eclr, wr_pol, wr_type;

  assign idx   = wr_data_i[IDX_W-1:0];
  assign wmask = wr_data_i[N_SRC-1:0];

  if (POW2) begin : g_idx_pow2
    assign idx_ok = 1'b1;
  end else begin : g_idx_rng
    assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(N_SRC));
  end

  always_comb begin
    idx_hot = '0;
    if (idx_ok) idx_hot[idx] = 1'b1;
  end

  assign wr_glb   = wr_en_i && (wr_addr_i == REG_GLB);
  assign wr_pend  = wr_en_i && (wr_addr_i == REG_PEND);
  assign wr_en    = wr_en_i && (wr_addr_i == REG_EN);
  assign wr_piclr = wr_en_i && (wr_addr_i == REG_PEND_ICLR);
  assign wr_eset  = wr_en_i && (wr_addr_i == REG_EN_ISET);
  assign wr_eclr  = wr_en_i && (wr_addr_i == REG_EN_ICLR);
  assign wr_pol   = wr_en_i && (wr_addr_i == REG_POL);
  assign wr_type  = wr_en_i && (wr_addr_i == REG_TYPE);

  always_comb begin
    pend_clr_o = '0;
    if (wr_pend)  pend_clr_o = wmask;
    if (wr_piclr) pend_clr_o = idx_hot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q  <= 1'b0;
      en_q   <= '0;
      pol_q  <= '1;  // level-high default: idle-low inputs stay quiet
      type_q <= '0;
    end else begin
      if (wr_glb)  glb_q  <= wr_data_i[0];
      if (wr_pol)  pol_q  <= wmask;
      if (wr_type) type_q <= wmask;
      if (wr_en)        en_q <= en_q & ~wmask;
      else if (wr_eset) en_q <= en_q | idx_hot;
      else if (wr_eclr) en_q <= en_q & ~idx_hot;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      REG_GLB:  rd_data_o = DATA_W'(glb_q);
      REG_PEND: rd_data_o = DATA_W'(pend_i);
      REG_EN:   rd_data_o = DATA_W'(en_q);
      REG_POL:  rd_data_o = DATA_W'(pol_q);
      REG_TYPE: rd_data_o = DATA_W'(type_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign type_o = type_q;
  assign glb_o  = glb_q;

  // R8
  en_iset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_eset && idx_ok) |=> en_q[$past(idx)]);

  // R8
  en_iclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_eclr && idx_ok) |=> !en_q[$past(idx)]);

  // R9
  en_bulk_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && (&wmask)) |=> (en_q == '0));

endmodule

// File: rtl/irq_cap_src.sv
module irq_cap_src
  import irq_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic type_i,
  input  logic clr_i,
  output logic pend_o
);

  logic  in_q;
  logic  hit;
  logic  pend_q;
  trig_e mode;

  assign mode = trig_e'({type_i, pol_i});

  always_comb begin
    unique case (mode)
      TRIG_RISE:   hit =  src_i & ~in_q;
      TRIG_FALL:   hit = ~src_i &  in_q;
      TRIG_LVL_HI: hit =  src_i;
      default:     hit = ~src_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      in_q   <= src_i;
      pend_q <= hit | (pend_q & ~clr_i);  // new trigger beats clear
    end
  end

  assign pend_o = pend_q;

  // R3
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_i && pol_i && $rose(src_i)) |=> pend_o);

  // R4
  fall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (type_i && !pol_i && $fell(src_i)) |=> pend_o);

  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);

  // R11
  lvl_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!type_i && (src_i == pol_i) && clr_i) |=> pend_o);

endmodule

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import irq_cap_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N_SRC-1:0]  irq_o
);

  logic [N_SRC-1:0] pend, pend_clr, en, pol, typ;
  logic             glb;

  irq_cap_regfile #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .pend_i     (pend),
    .pend_clr_o (pend_clr),
    .en_o       (en),
    .pol_o      (pol),
    .type_o     (typ),
    .glb_o      (glb)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    irq_cap_src u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[i]),
      .pol_i  (pol[i]),
      .type_i (typ[i]),
      .clr_i  (pend_clr[i]),
      .pend_o (pend[i])
    );
  end

  assign irq_o = pend & en & {N_SRC{glb}};

  // R10
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb |-> (irq_o == '0));

  // R12
  irq_has_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~pend) == '0));

endmodule

// File: tb/irq_src_capture_bench.sv
`timescale 1ns/1ps
module irq_src_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_src_capture u_irq_src_capture (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .src_i     (src),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] v;
    logic [31:0] e;
  } vec_t;

  // src bit0 rising, bit1 falling, bit2 level high, bit3 level low
  localparam vec_t TBL [21] = '{
    '{1'b1, 4'h0, 32'h1,        32'h0, 32'h0},
    '{1'b1, 4'h4, 32'h0,        32'h0, 32'h0},
    '{1'b1, 4'h4, 32'h1,        32'h0, 32'h0},
    '{1'b1, 4'h4, 32'h2,        32'h0, 32'h0},
    '{1'b1, 4'h4, 32'h3,        32'h0, 32'h0},
    '{1'b1, 4'h7, 32'h3,        32'hA, 32'hA},
    '{1'b1, 4'h6, 32'hFFFFFFF5, 32'hA, 32'hA},
    '{1'b1, 4'h1, 32'hFFFFFFFF, 32'hA, 32'h0},
    '{1'b0, 4'hF, 32'h0,        32'hB, 32'h1},
    '{1'b0, 4'hF, 32'h0,        32'hA, 32'h1},
    '{1'b1, 4'h3, 32'h0,        32'hA, 32'h0},
    '{1'b0, 4'hF, 32'h0,        32'h8, 32'h2},
    '{1'b0, 4'hF, 32'h0,        32'h8, 32'h2},
    '{1'b1, 4'h3, 32'h1,        32'h8, 32'h0},
    '{1'b0, 4'hF, 32'h0,        32'hC, 32'h4},
    '{1'b1, 4'h3, 32'h2,        32'hC, 32'h4},
    '{1'b0, 4'hF, 32'h0,        32'h8, 32'h4},
    '{1'b1, 4'h3, 32'h2,        32'h8, 32'h0},
    '{1'b0, 4'hF, 32'h0,        32'h0, 32'h8},
    '{1'b0, 4'hF, 32'h0,        32'h8, 32'h8},
    '{1'b1, 4'h3, 32'h3,        32'h8, 32'h0}
  };

  function automatic string tbl_req(int i);
    if (i <= 6)  return "R2";
    if (i == 7)  return "R9";
    if (i <= 10) return "R3";
    if (i <= 13) return "R4";
    if (i <= 17) return "R5";
    return "R6";
  endfunction

  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d, input logic [31:0] v);
    wr_en = w; wr_addr = a; wr_data = d; src = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_irq(input string req, input logic [31:0] exp);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq_o act=%h exp=%h", req, irq, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s read addr %0h act=%h exp=%h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq("R1", 32'h0);
    chk_rd("R1", 4'h1, 32'h0);
    chk_rd("R1", 4'h2, 32'h0);
    chk_rd("R1", 4'h0, 32'h0);
    chk_rd("R1", 4'h6, 32'hFFFFFFFF);
    chk_rd("R1", 4'h7, 32'h0);

    for (int i = 0; i < 21; i++) begin
      cyc(TBL[i].w, TBL[i].a, TBL[i].d, TBL[i].v);
      chk_irq(tbl_req(i), TBL[i].e);
    end

    // R11 edge and index clear in the same cycle
    cyc(1'b1, 4'h3, 32'h0, 32'h9);
    chk_irq("R11", 32'h1);
    cyc(1'b1, 4'h3, 32'h0, 32'h9);
    chk_irq("R11", 32'h0);

    // R10 global gate
    cyc(1'b1, 4'h0, 32'h0, 32'h9);
    cyc(1'b0, 4'hF, 32'h0, 32'hD);
    chk_irq("R10", 32'h0);
    chk_rd("R12", 4'h1, 32'h4);
    cyc(1'b1, 4'h0, 32'h1, 32'hD);
    chk_irq("R10", 32'h4);
    cyc(1'b1, 4'h3, 32'h2, 32'h9);
    chk_irq("R5", 32'h0);

    // R8 index enable clear/set
    cyc(1'b1, 4'h5, 32'h0, 32'h9);
    chk_rd("R8", 4'h2, 32'hE);
    cyc(1'b0, 4'hF, 32'h0, 32'h8);
    cyc(1'b0, 4'hF, 32'h0, 32'h9);
    chk_irq("R8", 32'h0);
    chk_rd("R12", 4'h1, 32'h1);
    cyc(1'b1, 4'h4, 32'h0, 32'h9);
    chk_irq("R12", 32'h1);
    chk_rd("R8", 4'h2, 32'hF);

    // R7 index clear leaves other sources
    cyc(1'b0, 4'hF, 32'h0, 32'hD);
    chk_irq("R7", 32'h5);
    cyc(1'b0, 4'hF, 32'h0, 32'h9);
    cyc(1'b1, 4'h3, 32'h2, 32'h9);
    chk_irq("R7", 32'h1);

    // R9 bulk clears
    cyc(1'b1, 4'h2, 32'hFFFFFFFF, 32'h9);
    chk_irq("R9", 32'h0);
    chk_rd("R9", 4'h2, 32'h0);
    cyc(1'b1, 4'h1, 32'hFFFFFFFF, 32'h9);
    chk_rd("R9", 4'h1, 32'h0);

    // R2 readback
    chk_rd("R2", 4'h6, 32'hFFFFFFF5);
    chk_rd("R2", 4'h7, 32'h3);
    chk_rd("R2", 4'h0, 32'h1);
    chk_rd("R2", 4'h8, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule